// File: doc/BRIEF.md
# Serial Pseudo-SRAM Host Controller (single and quad lane)

This block sits on the host side of a serial pseudo-SRAM link. It drives one active-low chip select, a serial clock and four data lanes, each with its own output enable. A client hands it one request at a time on a valid/ready port. Each request carries a command code, a 24-bit byte address and a byte count. For writes the block pulls payload bytes one by one through `wr_data`, raising `wr_ack` once for each byte it has taken. For reads it hands back each byte with a one-cycle `rd_valid` strobe.

Each frame starts with the opcode, followed by the address (most significant bit first) and any dummy clocks, then the data. Frames use one lane or four lanes, depending on the current link mode and the command. The block keeps track of whether the memory is in single-lane or quad mode, and changes that state only when a mode switch command has finished on the wire. After reset it holds the pins quiet for a programmable start-up time, then gives one clock pulse with the chip select high. It then accepts requests.

Long transfers are cut into several frames. No frame carries more than a set number of bytes, and no frame crosses a page boundary. Between frames the chip select goes high for at least one clock pulse, so the memory can refresh. Output bits change on the falling clock edge, and read data is captured on the rising edge.

Top module: `psram_host`

## Requirements
- R1: For PWR_CYCLES clock cycles after reset, `sclk` is low, `ce_n` is high, `sio_oe` is 4'hF with `sio_out` all zero, and `req_ready` is low.
- R2: After the start-up time and before the first falling edge of `ce_n`, at least one rising edge of `sclk` occurs while `ce_n` is high.
- R3: Command codes on `req_cmd` are: 0 = 03h read, 1 = 0Bh fast read, 2 = EBh quad read, 3 = 02h write, 4 = 38h quad write, 5 = 35h enter quad mode, 6 = F5h leave quad mode. In single-lane mode, 03h and 02h send the opcode, then the 24-bit address MSB first, then write data MSB first, one bit per clock on `sio_out[0]`. Read data is taken from `sio_in[1]` on the rising edge. 03h has no dummy clocks. Read bytes come out on `rd_data` in address order.
- R4: In single-lane mode, 0Bh is sent serially and followed by 8 dummy clocks. EBh and 38h send the opcode serially and then the address and data on four lanes, high nibble first with lane 3 as the MSB. EBh adds 6 dummy clocks and 38h adds none.
- R5: A completed 35h sets `qpi_mode`, and a completed F5h clears it. In quad mode, every phase uses four lanes. 0Bh and EBh then add 6 dummy clocks, and 02h and 38h add none. `qpi_mode` changes only while `ce_n` is high.
- R6: The following requests are dropped without any `ce_n` activity and raise `cmd_err` for one cycle: 35h in quad mode, F5h in single-lane mode, 03h in quad mode, a data command with a length of zero, and code 7. The mode is left unchanged.
- R7: Every frame ends with `ce_n` high for at least one full `sclk` pulse before `ce_n` falls again.
- R8: One `ce_n` low frame never carries more than MAX_BURST data bytes. The remaining bytes follow in further frames at the next address.
- R9: No frame's data crosses a PAGE_BYTES address boundary.
- R10: During a 03h frame, each `sclk` level lasts SLOW_HALF clock cycles. For every other command it lasts FAST_HALF cycles.
- R11: The lanes are driven only as follows. Single-lane command and address phases drive `sio_oe` = 4'b0001. Quad phases drive 4'hF. Dummy clocks and read data release all lanes (4'h0).
- R12: `ce_n` never stays low longer than 2·max(FAST_HALF,SLOW_HALF)·(40+8·MAX_BURST)+4 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, takes a request |
| req_cmd | input | 3 | Command code (see R3) |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Byte count |
| wr_data | input | 8 | Next write payload byte |
| wr_ack | output | 1 | Pulse: `wr_data` was taken |
| rd_valid | output | 1 | Pulse: `rd_data` holds a read byte |
| rd_data | output | 8 | Read byte |
| cmd_err | output | 1 | Pulse: request was dropped |
| qpi_mode | output | 1 | Link is in quad mode |
| sclk | output | 1 | Serial clock, idle low |
| ce_n | output | 1 | Chip select, active low |
| sio_out | output | 4 | Lane output values |
| sio_oe | output | 4 | Lane output enables |
| sio_in | input | 4 | Lane input values |

## Verification
Payloads are written and read back in both modes, through every command variant, using a lane-level memory model in the bench. A serial write followed by a quad read, and the reverse, shows that the lane width and dummy count of each opcode agree with the model. A mismatch shifts the bytes and shows up at once. Transfers that start four bytes before a page end, and transfers longer than the burst cap, tell the page cut apart from the burst cut. Mode commands are issued both in the correct order and in the redundant order, which shows that only legal switches change the mode while illegal ones are flagged and never reach the pins.

// File: rtl/psram_host_pkg.sv
package psram_host_pkg;

  typedef enum logic [2:0] {
    CMD_READ    = 3'd0,
    CMD_FAST    = 3'd1,
    CMD_QREAD   = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_QWRITE  = 3'd4,
    CMD_QPI_ON  = 3'd5,
    CMD_QPI_OFF = 3'd6,
    CMD_BAD     = 3'd7
  } cmd_e;

  typedef enum logic [3:0] {
    S_PWR, S_RCLK, S_IDLE, S_CMD, S_ADDR, S_WAIT, S_WDAT, S_RDAT, S_GAP
  } st_e;

  function automatic logic [7:0] opcode_of(cmd_e c);
    case (c)
      CMD_READ:    return 8'h03;
      CMD_FAST:    return 8'h0B;
      CMD_QREAD:   return 8'hEB;
      CMD_WRITE:   return 8'h02;
      CMD_QWRITE:  return 8'h38;
      CMD_QPI_ON:  return 8'h35;
      CMD_QPI_OFF: return 8'hF5;
      default:     return 8'h00;
    endcase
  endfunction

  function automatic logic is_mode(cmd_e c);
    return (c == CMD_QPI_ON) || (c == CMD_QPI_OFF);
  endfunction

  function automatic logic is_wr(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_QWRITE);
  endfunction

  // address and data phases on four lanes
  function automatic logic wide_data(cmd_e c, logic qpi);
    return qpi || (c == CMD_QREAD) || (c == CMD_QWRITE);
  endfunction

  function automatic logic [3:0] dummy_of(cmd_e c, logic qpi);
    if (qpi) return ((c == CMD_FAST) || (c == CMD_QREAD)) ? 4'd6 : 4'd0;
    if (c == CMD_FAST) return 4'd8;
    if (c == CMD_QREAD) return 4'd6;
    return 4'd0;
  endfunction

endpackage

// File: rtl/psram_powerup.sv
module psram_powerup #(
  parameter int PWR_CYCLES = 30000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(PWR_CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(PWR_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (!done) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/psram_halftick.sv
module psram_halftick #(
  parameter int HALF_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = run && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/psram_chunk.sv
module psram_chunk #(
  parameter int LEN_W      = 16,
  parameter int BURST_W    = 6,
  parameter int MAX_BURST  = 32,
  parameter int PAGE_BYTES = 1024
) (
  input  logic [23:0]        addr,
  input  logic [LEN_W-1:0]   rem,
  output logic [BURST_W-1:0] len
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [31:0] to_page, lim, pick;

  always_comb begin
    to_page = 32'(PAGE_BYTES) - 32'(addr[PAGE_W-1:0]);
    lim     = (to_page < 32'(MAX_BURST)) ? to_page : 32'(MAX_BURST);
    pick    = (32'(rem) < lim) ? 32'(rem) : lim;
    len     = pick[BURST_W-1:0];
  end
endmodule

// File: rtl/psram_host.sv
module psram_host
  import psram_host_pkg::*;
#(
  parameter int PWR_CYCLES = 30000,
  parameter int FAST_HALF  = 1,
  parameter int SLOW_HALF  = 4,
  parameter int MAX_BURST  = 32,
  parameter int PAGE_BYTES = 1024,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_cmd,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_ack,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             cmd_err,
  output logic             qpi_mode,
  output logic             sclk,
  output logic             ce_n,
  output logic [3:0]       sio_out,
  output logic [3:0]       sio_oe,
  input  logic [3:0]       sio_in
);
  localparam int HALF_MAX = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int HALF_W   = $clog2(HALF_MAX + 1);
  localparam int BURST_W  = $clog2(MAX_BURST + 1);

  st_e                st;
  cmd_e               cmd_q;
  logic               qpi, ce_q, sclk_q, wid4, slow;
  logic [3:0]         oe_q;
  logic [31:0]        sh;
  logic [4:0]         bcnt;
  logic [23:0]        addr_q;
  logic [LEN_W-1:0]   rem_q;
  logic [BURST_W-1:0] left_q, chunk_len;
  logic [7:0]         rsh, rd_q, rnext;
  logic               wr_ack_q, rd_valid_q, err_q;
  logic               pwr_done, tick, rise, fall, run, go, bad_req;
  cmd_e               req_c, f_cmd;
  logic               dq, wr;
  logic [3:0]         wn;
  logic [HALF_W-1:0]  half;

  psram_powerup #(.PWR_CYCLES(PWR_CYCLES)) u_pwr (
    .clk(clk), .rst(rst), .done(pwr_done)
  );

  assign run  = (st != S_PWR) && (st != S_IDLE);
  assign half = slow ? HALF_W'(SLOW_HALF) : HALF_W'(FAST_HALF);

  psram_halftick #(.HALF_W(HALF_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .half(half), .tick(tick)
  );

  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;

  assign req_c = cmd_e'(req_cmd);
  assign f_cmd = (st == S_IDLE) ? req_c : cmd_q;

  psram_chunk #(.LEN_W(LEN_W), .BURST_W(BURST_W), .MAX_BURST(MAX_BURST),
                .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .addr((st == S_IDLE) ? req_addr : addr_q),
    .rem ((st == S_IDLE) ? req_len  : rem_q),
    .len (chunk_len)
  );

  always_comb begin
    bad_req = (req_c == CMD_BAD)
           || (req_c == CMD_QPI_ON  &&  qpi)
           || (req_c == CMD_QPI_OFF && !qpi)
           || (req_c == CMD_READ    &&  qpi)
           || (!is_mode(req_c) && req_len == '0);
    go = (st == S_IDLE && req_valid && !bad_req)
      || (st == S_GAP && fall && !is_mode(cmd_q) && rem_q != '0);
    dq    = wide_data(cmd_q, qpi);
    wn    = dummy_of(cmd_q, qpi);
    wr    = is_wr(cmd_q);
    rnext = wid4 ? {rsh[3:0], sio_in} : {rsh[6:0], sio_in[1]};
  end

  always_ff @(posedge clk) begin
    wr_ack_q   <= 1'b0;
    rd_valid_q <= 1'b0;
    err_q      <= 1'b0;
    if (rst) begin
      st <= S_PWR; cmd_q <= CMD_READ; qpi <= 1'b0; ce_q <= 1'b1;
      sclk_q <= 1'b0; oe_q <= 4'hF; sh <= '0; wid4 <= 1'b0; slow <= 1'b0;
      bcnt <= '0; addr_q <= '0; rem_q <= '0; left_q <= '0;
      rsh <= '0; rd_q <= '0;
    end else begin
      case (st)
        S_PWR: if (pwr_done) st <= S_RCLK;
        S_RCLK: begin
          if (rise) sclk_q <= 1'b1;
          else if (fall) begin sclk_q <= 1'b0; oe_q <= 4'h0; st <= S_IDLE; end
        end
        S_IDLE: if (req_valid) begin
          cmd_q  <= req_c;
          addr_q <= req_addr;
          rem_q  <= is_mode(req_c) ? '0 : req_len;
          if (bad_req) err_q <= 1'b1;
        end
        S_GAP: begin
          if (rise) sclk_q <= 1'b1;
          else if (fall) begin
            sclk_q <= 1'b0;
            if (is_mode(cmd_q)) qpi <= (cmd_q == CMD_QPI_ON);
            st <= S_IDLE;
          end
        end
        default: begin
          if (rise) begin
            sclk_q <= 1'b1;
            if (st == S_RDAT) begin
              rsh <= rnext;
              if (bcnt == '0) begin rd_valid_q <= 1'b1; rd_q <= rnext; end
            end
          end else if (fall) begin
            sclk_q <= 1'b0;
            if (bcnt != '0) begin
              bcnt <= bcnt - 5'd1;
              if (st != S_RDAT && st != S_WAIT) sh <= wid4 ? (sh << 4) : (sh << 1);
            end else begin
              case (st)
                S_CMD: begin
                  if (is_mode(cmd_q)) begin
                    st <= S_GAP; ce_q <= 1'b1; oe_q <= 4'h0;
                  end else begin
                    st <= S_ADDR; sh <= {addr_q, 8'h00}; wid4 <= dq;
                    oe_q <= dq ? 4'hF : 4'h1; bcnt <= dq ? 5'd5 : 5'd23;
                  end
                end
                S_ADDR: begin
                  if (wn != '0) begin
                    st <= S_WAIT; oe_q <= 4'h0; bcnt <= 5'(wn) - 5'd1;
                  end else if (wr) begin
                    st <= S_WDAT; sh <= {wr_data, 24'h0}; wr_ack_q <= 1'b1;
                    bcnt <= dq ? 5'd1 : 5'd7;
                  end else begin
                    st <= S_RDAT; oe_q <= 4'h0; bcnt <= dq ? 5'd1 : 5'd7;
                  end
                end
                S_WAIT: begin st <= S_RDAT; bcnt <= dq ? 5'd1 : 5'd7; end
                default: begin
                  left_q <= left_q - BURST_W'(1);
                  addr_q <= addr_q + 24'd1;
                  rem_q  <= rem_q - LEN_W'(1);
                  if (left_q == BURST_W'(1)) begin
                    st <= S_GAP; ce_q <= 1'b1; oe_q <= 4'h0;
                  end else if (st == S_WDAT) begin
                    sh <= {wr_data, 24'h0}; wr_ack_q <= 1'b1;
                    bcnt <= dq ? 5'd1 : 5'd7;
                  end else begin
                    bcnt <= dq ? 5'd1 : 5'd7;
                  end
                end
              endcase
            end
          end
        end
      endcase
      if (go) begin
        st     <= S_CMD;
        ce_q   <= 1'b0;
        sh     <= {opcode_of(f_cmd), 24'h0};
        wid4   <= qpi;
        oe_q   <= qpi ? 4'hF : 4'h1;
        bcnt   <= qpi ? 5'd1 : 5'd7;
        left_q <= chunk_len;
        slow   <= (f_cmd == CMD_READ);
      end
    end
  end

  genvar i;
  generate
    for (i = 0; i < 4; i++) begin : g_lane
      if (i == 0) begin : g_l0
        assign sio_out[i] = wid4 ? sh[28] : sh[31];
      end else begin : g_ln
        assign sio_out[i] = wid4 ? sh[28+i] : 1'b0;
      end
    end
  endgenerate

  assign req_ready = (st == S_IDLE);
  assign sio_oe    = oe_q;
  assign sclk      = sclk_q;
  assign ce_n      = ce_q;
  assign qpi_mode  = qpi;
  assign wr_ack    = wr_ack_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_q;
  assign cmd_err   = err_q;

endmodule

// File: rtl/psram_host_chk.sv
module psram_host_chk #(
  parameter int PWR_CYCLES = 30000,
  parameter int FAST_HALF  = 1,
  parameter int SLOW_HALF  = 4,
  parameter int MAX_BURST  = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       cmd_err,
  input logic       qpi_mode,
  input logic       sclk,
  input logic       ce_n,
  input logic [3:0] sio_out,
  input logic [3:0] sio_oe
);
  localparam int HALF_MAX = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int LOW_MAX  = 2 * HALF_MAX * (40 + 8 * MAX_BURST) + 4;

  logic [31:0] pc, low_cnt;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else if (pc < 32'(PWR_CYCLES)) pc <= pc + 32'd1;
    if (rst || ce_n) low_cnt <= '0;
    else low_cnt <= low_cnt + 32'd1;
  end

  assert_pwr_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (pc < 32'(PWR_CYCLES)) |-> (ce_n && !sclk && !req_ready && sio_oe == 4'hF && sio_out == 4'h0));

  assert_rd_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!ce_n && sio_oe == 4'h0));

  assert_mode_change_ce_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(qpi_mode) |-> ce_n);

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (ce_n && req_ready));

  assert_oe_legal_R11: assert property (@(posedge clk) disable iff (rst)
    (sio_oe == 4'h0 || sio_oe == 4'h1 || sio_oe == 4'hF));

  assert_ce_bound_R12: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= 32'(LOW_MAX));

endmodule

bind psram_host psram_host_chk #(
  .PWR_CYCLES(PWR_CYCLES), .FAST_HALF(FAST_HALF),
  .SLOW_HALF(SLOW_HALF), .MAX_BURST(MAX_BURST)
) u_chk (.*);

// File: tb/psram_host_test.sv
`timescale 1ns/1ps
module psram_host_test;
  localparam int PWR  = 400;
  localparam int FH   = 1;
  localparam int SH   = 4;
  localparam int MB   = 8;
  localparam int PAGE = 1024;
  localparam int LW   = 16;
  localparam int LOW_MAX = 2 * SH * (40 + 8 * MB) + 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [2:0] req_cmd = 0;
  logic [23:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic [7:0] wr_data, rd_data;
  logic wr_ack, rd_valid, cmd_err, qpi_mode, sclk, ce_n;
  logic [3:0] sio_out, sio_oe;
  logic [3:0] sio_in = 0;

  always #2.5 clk = ~clk;

  psram_host #(.PWR_CYCLES(PWR), .FAST_HALF(FH), .SLOW_HALF(SH),
               .MAX_BURST(MB), .PAGE_BYTES(PAGE), .LEN_W(LW)) uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // write payload feed
  logic [7:0] wbuf [64];
  int widx = 0;
  assign wr_data = wbuf[widx];
  always @(negedge clk) if (wr_ack) widx++;

  // scoreboard
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];
  string cur_tag = "R3";
  always @(negedge clk) if (rd_valid) begin
    if (exp_q.size() == 0) chk(0, cur_tag, "unexpected read byte", rd_data, -1);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rd_data == e, cur_tag, "read byte", rd_data, e);
    end
  end

  // counters on pins
  int err_cnt = 0, ce_falls = 0, hi_rises = 0, hcnt = 0, last_hw = 0;
  int low_cnt = 0, max_low = 0, oe_bad = 0;
  always @(negedge clk) begin
    if (!rst && cmd_err) err_cnt++;
    if (sclk && !ce_n) hcnt++;
    else if (hcnt != 0) begin last_hw = hcnt; hcnt = 0; end
    if (!ce_n) begin low_cnt++; if (low_cnt > max_low) max_low = low_cnt; end
    else low_cnt = 0;
  end
  always @(posedge sclk) if (ce_n === 1'b1) hi_rises++;
  always @(negedge ce_n) if (!rst) begin
    chk(hi_rises >= 1, (ce_falls == 0) ? "R2" : "R7", "sclk pulses with ce_n high", hi_rises, 1);
    hi_rises = 0;
    ce_falls++;
  end

  // lane-level memory model
  logic [7:0] mem [int];
  int m_e = 0, m_nb = 0;
  logic [7:0] m_cmd = 0, m_byte = 0;
  logic [23:0] m_addr = 0;
  logic m_qpi = 0;

  function automatic bit m_q();   return m_qpi || m_cmd == 8'hEB || m_cmd == 8'h38; endfunction
  function automatic int m_ce();  return m_qpi ? 2 : 8; endfunction
  function automatic int m_ae();  return m_q() ? 6 : 24; endfunction
  function automatic int m_bpb(); return m_q() ? 2 : 8; endfunction
  function automatic int m_wt();
    if (m_qpi) return (m_cmd == 8'h0B || m_cmd == 8'hEB) ? 6 : 0;
    return (m_cmd == 8'h0B) ? 8 : (m_cmd == 8'hEB) ? 6 : 0;
  endfunction
  function automatic int m_h(); return m_ce() + m_ae() + m_wt(); endfunction
  function automatic bit m_rd(); return m_cmd == 8'h03 || m_cmd == 8'h0B || m_cmd == 8'hEB; endfunction
  function automatic bit m_wr(); return m_cmd == 8'h02 || m_cmd == 8'h38; endfunction

  always @(posedge sclk) if (ce_n === 1'b0) begin
    logic [3:0] p;
    p = sio_out & sio_oe;
    m_e++;
    if (m_e <= m_ce()) begin
      if (sio_oe != (m_qpi ? 4'hF : 4'h1)) oe_bad++;
      m_cmd = m_qpi ? {m_cmd[3:0], p} : {m_cmd[6:0], p[0]};
    end else if (m_e <= m_ce() + m_ae()) begin
      if (sio_oe != (m_q() ? 4'hF : 4'h1)) oe_bad++;
      m_addr = m_q() ? {m_addr[19:0], p} : {m_addr[22:0], p[0]};
    end else if (m_rd()) begin
      if (sio_oe != 4'h0) oe_bad++;
    end else if (m_wr() && m_e > m_h()) begin
      m_byte = m_q() ? {m_byte[3:0], p} : {m_byte[6:0], p[0]};
      if ((m_e - m_h()) % m_bpb() == 0) begin
        mem[int'(m_addr) + m_nb] = m_byte;
        m_nb++;
      end
    end
  end

  always @(negedge sclk) if (ce_n === 1'b0 && m_rd() && m_e >= m_h()) begin
    int k, a;
    logic [7:0] b;
    k = m_e - m_h();
    a = int'(m_addr) + k / m_bpb();
    b = mem.exists(a) ? mem[a] : 8'h00;
    if (m_q()) sio_in = (k % 2 == 0) ? b[7:4] : b[3:0];
    else sio_in = {2'b00, b[7 - (k % 8)], 1'b0};
  end

  always @(posedge ce_n) if (!rst) begin
    if ((m_rd() || m_wr()) && m_e > m_h()) begin
      int nb;
      nb = (m_e - m_h()) / m_bpb();
      chk(nb <= MB, "R8", "bytes in one frame", nb, MB);
      chk((int'(m_addr) % PAGE) + nb <= PAGE, "R9", "frame end within page",
          (int'(m_addr) % PAGE) + nb, PAGE);
    end
    if (m_e >= m_ce()) begin
      if (m_cmd == 8'h35) m_qpi = 1;
      if (m_cmd == 8'hF5) m_qpi = 0;
    end
    m_e = 0; m_nb = 0; m_cmd = 0; sio_in = 0;
  end

  // driver
  task automatic issue(input logic [2:0] c, input logic [23:0] a, input int n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = c; req_addr = a; req_len = LW'(n); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic write_seq(input logic [2:0] c, input logic [23:0] a, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      wbuf[i] = 8'(seed + i * 37);
      shadow[int'(a) + i] = wbuf[i];
    end
    widx = 0;
    issue(c, a, n);
  endtask

  task automatic read_seq(input logic [2:0] c, input logic [23:0] a, input int n, input string tag);
    cur_tag = tag;
    for (int i = 0; i < n; i++) exp_q.push_back(shadow[int'(a) + i]);
    issue(c, a, n);
    chk(exp_q.size() == 0, tag, "bytes still owed", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic try_bad(input logic [2:0] c, input int n, input bit exp_q_mode, input string what);
    int e0, f0;
    e0 = err_cnt; f0 = ce_falls;
    issue(c, 24'h000010, n);
    chk(err_cnt == e0 + 1, "R6", {what, ": cmd_err pulses"}, err_cnt - e0, 1);
    chk(ce_falls == f0, "R6", {what, ": ce_n falls"}, ce_falls - f0, 0);
    chk(qpi_mode == exp_q_mode, "R6", {what, ": mode kept"}, qpi_mode, exp_q_mode);
  endtask

  initial begin
    bit pok, rdy_low;
    pok = 1; rdy_low = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: start-up hold
    for (int i = 0; i < PWR - 4; i++) begin
      @(negedge clk);
      if (!(ce_n && !sclk && sio_oe == 4'hF && sio_out == 4'h0)) pok = 0;
      if (req_ready) rdy_low = 0;
    end
    chk(pok, "R1", "pins quiet during start-up", pok, 1);
    chk(rdy_low, "R1", "req_ready low during start-up", rdy_low, 1);
    chk(qpi_mode == 0, "R1", "reset mode single-lane", qpi_mode, 0);

    // R3 serial write/read, R10 slow clock
    write_seq(3'd3, 24'h000100, 5, 8'h11);
    read_seq(3'd0, 24'h000100, 5, "R3");
    chk(last_hw == SH, "R10", "sclk high width for 03h", last_hw, SH);
    // R4 fast read with 8 dummies
    read_seq(3'd1, 24'h000100, 5, "R4");
    chk(last_hw == FH, "R10", "sclk high width for 0Bh", last_hw, FH);
    // R4 quad write/read across a page end (R9)
    write_seq(3'd4, 24'h0003FC, 6, 8'h5A);
    read_seq(3'd2, 24'h0003FC, 6, "R4");
    read_seq(3'd0, 24'h0003FC, 6, "R9");
    // R8 burst cut
    write_seq(3'd3, 24'h002000, 20, 8'hC3);
    read_seq(3'd1, 24'h002000, 20, "R8");
    read_seq(3'd2, 24'h002000, 20, "R8");

    // R6 illegal in single-lane mode
    try_bad(3'd6, 1, 0, "F5h in single-lane");
    try_bad(3'd0, 0, 0, "zero length");
    try_bad(3'd7, 1, 0, "code 7");

    // R5 enter quad mode
    issue(3'd5, 24'h0, 1);
    chk(qpi_mode == 1, "R5", "mode after 35h", qpi_mode, 1);
    try_bad(3'd5, 1, 1, "35h in quad");
    try_bad(3'd0, 4, 1, "03h in quad");
    write_seq(3'd3, 24'h001234, 3, 8'h7E);
    read_seq(3'd1, 24'h001234, 3, "R5");
    read_seq(3'd2, 24'h001234, 3, "R5");
    write_seq(3'd4, 24'h0007FA, 12, 8'h29);
    read_seq(3'd2, 24'h0007FA, 12, "R5");
    read_seq(3'd1, 24'h002000, 20, "R5");
    issue(3'd6, 24'h0, 1);
    chk(qpi_mode == 0, "R5", "mode after F5h", qpi_mode, 0);
    read_seq(3'd0, 24'h0007FA, 12, "R5");
    read_seq(3'd2, 24'h001234, 3, "R4");

    chk(oe_bad == 0, "R11", "lane enable violations", oe_bad, 0);
    chk(max_low <= LOW_MAX && max_low > 0, "R12", "longest ce_n low", max_low, LOW_MAX);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule